// File: doc/BRIEF.md
# Single-Port RAM Queue

This block is a first-in-first-out queue whose storage is one synchronous single-port RAM, 1024 words deep by default. A head pointer marks the oldest stored word and a tail pointer marks the next free slot. An address selector gives the RAM the tail pointer on writes and the head pointer on reads. Because the RAM has only one port, it serves at most one access per clock cycle.

The user drives an enable line and an operation select, where 1 means write and 0 means read. `empty` and `full` are plain status outputs, and they are the queue's back-pressure signals. A write presented while `full` is high is dropped. A read presented while `empty` is high is dropped. The user must not count on either being held over for a later cycle. Data read out appears one cycle after the accepted read, qualified by a one-cycle `rd_valid` strobe. `rd_data` keeps its value until the next accepted read.

Top module: `ramq_fifo`

## Requirements
- R1: While reset is active and right after it, `empty` is 1, `full` is 0, `rd_valid` is 0 and `rd_data` is zero.
- R2: With `en` = 0, neither pointer moves and the RAM is not selected. On the next cycle `empty` and `full` are unchanged and `rd_valid` is 0, whatever `rw` and `wr_data` are.
- R3: With `en` = 1, `rw` = 1 and `full` = 0, `wr_data` is stored at the tail slot and the tail advances by one. `empty` is 0 on the following cycle.
- R4: With `en` = 1, `rw` = 0 and `empty` = 0, the word at the head slot is presented on `rd_data` on the following cycle, with `rd_valid` = 1. The head then advances by one.
- R5: Words come out in the order they went in, including when the pointers wrap past the last RAM address back to address 0.
- R6: `full` rises after exactly 2^AW accepted writes in excess of reads. `empty` is 1 exactly when the number of accepted reads equals the number of accepted writes. The two flags are never high together.
- R7: A write presented while `full` is 1 is ignored. `full` stays 1 and the queue's contents, read back in order, are unchanged.
- R8: A read presented while `empty` is 1 is ignored. `rd_valid` stays 0 on the next cycle and `empty` stays 1.
- R9: `rd_data` holds its value on every cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Operation enable |
| rw | input | 1 | Operation select: 1 = write, 0 = read |
| wr_data | input | DW | Word to store on a write |
| rd_data | output | DW | Word fetched by the last accepted read |
| rd_valid | output | 1 | High for one cycle when `rd_data` is new |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds 2^AW words |

## Verification
The assertions check the cycle-level rules on every cycle:
- the flags are never high together;
- an idle cycle changes no flag and yields no strobe;
- an accepted read is followed by a strobe, and a dropped read is not;
- a write leaves the queue non-empty, and a write while full leaves it full;
- read data stays put between strobes.

Some properties need whole scenarios from the bench:
- the order of the data words, including across the address wrap;
- the exact write count at which `full` rises;
- the integrity of the stored contents after a write is refused while full.

// File: rtl/ramq_pkg.sv
package ramq_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } ramq_op_e;
endpackage

// File: rtl/ramq_ptr.sv
module ramq_ptr #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [AW:0] ptr
);
  // AW address bits plus one lap bit above them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/ramq_flags.sv
module ramq_flags #(
  parameter int AW = 10
) (
  input  logic [AW:0] head,
  input  logic [AW:0] tail,
  output logic        empty,
  output logic        full
);
  logic same_slot;
  logic same_lap;

  always_comb begin
    same_slot = (head[AW-1:0] == tail[AW-1:0]);
    same_lap  = (head[AW] == tail[AW]);
    empty     = same_slot && same_lap;
    full      = same_slot && !same_lap;
  end
endmodule

// File: rtl/ramq_ram.sv
module ramq_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && we) cells[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata <= '0;
    else if (cs && !we)   rdata <= cells[addr];
  end
endmodule

// File: rtl/ramq_fifo.sv
module ramq_fifo #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rw,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          full
);
  import ramq_pkg::*;

  ramq_op_e      op;
  logic          do_wr;
  logic          do_rd;
  logic          ram_cs;
  logic [AW:0]   head_ptr;
  logic [AW:0]   tail_ptr;
  logic [AW-1:0] ram_addr;

  always_comb begin
    op       = ramq_op_e'(rw);
    do_wr    = en && (op == OP_WRITE) && !full;
    do_rd    = en && (op == OP_READ)  && !empty;
    ram_cs   = do_wr || do_rd;
    ram_addr = (op == OP_WRITE) ? tail_ptr[AW-1:0] : head_ptr[AW-1:0];
  end

  ramq_ptr #(.AW(AW)) i_head (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (do_rd),
    .ptr   (head_ptr)
  );

  ramq_ptr #(.AW(AW)) i_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (do_wr),
    .ptr   (tail_ptr)
  );

  ramq_flags #(.AW(AW)) i_flags (
    .head  (head_ptr),
    .tail  (tail_ptr),
    .empty (empty),
    .full  (full)
  );

  ramq_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (ram_cs),
    .we    (do_wr),
    .addr  (ram_addr),
    .wdata (wr_data),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= do_rd;
  end
endmodule

// File: rtl/ramq_fifo_chk.sv
module ramq_fifo_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          rw,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          empty,
  input logic          full
);
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(empty) && $stable(full) && !rd_valid));

  a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rw && !empty) |=> rd_valid);

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rw && empty) |=> (!rd_valid && empty));

  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rw && !full) |=> !empty);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rw && full) |=> full);

  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

bind ramq_fifo ramq_fifo_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .rw       (rw),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .empty    (empty),
  .full     (full)
);

// File: tb/test_ramq_fifo.sv
module test_ramq_fifo;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC  = 12;

  // vector: {en, rw, wr_data[7:0], exp_empty, exp_valid, exp_rd_data[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00},  // R3 write
    {1'b1, 1'b1, 8'h22, 1'b0, 1'b0, 8'h00},  // R3 write
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},  // R2 idle
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h11},  // R4 read oldest
    {1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 8'h11},  // R2 disabled write, R9 hold
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h22},  // R4 read, R6 empty
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h22},  // R8 read while empty
    {1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 8'h22},  // R3
    {1'b1, 1'b1, 8'h44, 1'b0, 1'b0, 8'h22},  // R3
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h33},  // R4
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h44},  // R4, R6
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h44}   // R8, R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          rw = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          empty;
  logic          full;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ramq_fifo #(.AW(AW), .DW(DW)) i_ramq_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .rw       (rw),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .empty    (empty),
    .full     (full)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge apply it, return at next falling edge
  task automatic op(input logic e, input logic w, input logic [DW-1:0] d);
    en = e; rw = w; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0; rw = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 7) ^ (i >> 5) ^ 8'h5A);
  endfunction

  initial begin
    #(20 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    #35;
    check("R1 empty", 16'(empty), 16'd1);
    check("R1 full", 16'(full), 16'd0);
    check("R1 rd_valid", 16'(rd_valid), 16'd0);
    check("R1 rd_data", 16'(rd_data), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty after release", 16'(empty), 16'd1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      op(VEC[v][19], VEC[v][18], VEC[v][17:10]);
      check($sformatf("R2/R3/R4/R8 vec%0d empty", v), 16'(empty), 16'(VEC[v][9]));
      check($sformatf("R4/R8 vec%0d rd_valid", v), 16'(rd_valid), 16'(VEC[v][8]));
      check($sformatf("R9 vec%0d rd_data", v), 16'(rd_data), 16'(VEC[v][7:0]));
      check($sformatf("R6 vec%0d full", v), 16'(full), 16'd0);
    end

    // R6 fill to capacity; pointers start mid-array so the fill wraps (R5)
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) check("R6 not full one short", 16'(full), 16'd0);
      op(1'b1, 1'b1, pat(i));
    end
    check("R6 full at capacity", 16'(full), 16'd1);
    check("R6 not empty when full", 16'(empty), 16'd0);

    // R7 write while full is dropped
    op(1'b1, 1'b1, 8'hEE);
    check("R7 full stays", 16'(full), 16'd1);

    // R2 disabled cycle while full
    op(1'b0, 1'b0, 8'h00);
    check("R2 full unchanged", 16'(full), 16'd1);
    check("R2 no strobe", 16'(rd_valid), 16'd0);

    // R5 drain in order across the wrap
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b1, 1'b0, '0);
      check($sformatf("R5 order word %0d", i), 16'(rd_data), 16'(pat(i)));
      if (i == 0) check("R6 full drops after read", 16'(full), 16'd0);
    end
    check("R6 empty after drain", 16'(empty), 16'd1);

    // R8 read while empty: no strobe, the refused word 8'hEE never appears (R7)
    op(1'b1, 1'b0, '0);
    check("R8 no strobe", 16'(rd_valid), 16'd0);
    check("R7 dropped word absent", 16'(rd_data), 16'(pat(DEPTH - 1)));
    check("R8 still empty", 16'(empty), 16'd1);

    // reset in mid-use returns to R1 state
    op(1'b1, 1'b1, 8'h77);
    rst_n = 1'b0;
    #5;
    check("R1 empty on reset", 16'(empty), 16'd1);
    check("R1 rd_data on reset", 16'(rd_data), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule